// File: doc/BRIEF.md
# Self-Synchronising PRBS Checker with Lock Tracking

The block checks an incoming pseudo-random bit stream against the same maximal-length polynomial its generator uses. Bits arrive one word per clock, the word being one bit wide for a serial link or several bits wide for a parallel one. After reset the checker knows nothing about the sender's state. It copies the received bits into a local shift register, and once that register is full it keeps checking whether each new bit matches the polynomial's prediction. A run of matching predictions as long as the register puts it in lock.

While locked, the checker runs the shift register on its own predictions, so a corrupted received bit does not disturb later predictions. Each mismatching bit adds one to a 64-bit error counter, and each word checked adds one to a 64-bit word counter. Errors are also counted over fixed windows of checked bits. When too many fall in one window the checker gives up lock and starts hunting again. It relocks by itself once clean data returns.

Top module: `prbs_lock_checker`

## Requirements
- R1: While reset is high and in the cycle after it, `locked` is 0 and both counters are 0. Reset clears the counters at any time.
- R2: The feedback bit is `s[ORDER-1] ^ s[TAP-1]`. The register shifts left, taking the new bit into bit 0. TAP is 6, 5, 9, 14, 18 or 28 for ORDER 7, 9, 11, 15, 23 or 31. The first ORDER bits after reset only load the register. `locked` rises on the word that holds the ORDER-th consecutive correctly predicted bit after that. With a clean serial stream this is exactly the 2*ORDER-th word, and always within 2*(2^ORDER-1) cycles.
- R3: Bit 0 of `rx_word` is the earliest bit in time. A W-bit word is processed as W consecutive serial bits.
- R4: `word_count` rises by 1 for each word received while `locked` is 1 at the clock edge. This includes words with errors. It holds while unlocked.
- R5: For each word received while locked, `error_count` rises by the number of mismatching bits in that word. A single corrupted bit adds exactly 1 and lock is kept.
- R6: While locked, predictions come from the local register and not from received bits. A corrupted bit therefore causes no further errors on the clean words that follow.
- R7: Lock is dropped on the word that brings the errors within the current window to 8. A window is 64 checked bits (64/W words), and windows start at the word that follows the rise of `locked`. Seven errors within one window keep lock.
- R8: With every bit wrong, `error_count` rises by W on every locked word, and lock is lost within 2000 cycles.
- R9: While unlocked, `error_count` holds. After clean data resumes, lock is regained within 2*ORDER bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_word | input | W | Received bits, bit 0 earliest |
| locked | output | 1 | Checker is synchronised to the stream |
| word_count | output | CNT_W | Words checked while locked |
| error_count | output | CNT_W | Mismatching bits seen while locked |

## Verification
A clean stream from an independent model generator is used to pin the exact lock cycle in serial mode and in a 4-bit word mode with a different order. The word-mode case separates correct bit ordering from reversed ordering. Isolated single-bit and two-bit corruptions distinguish counting every mismatching bit from counting words. They also show that errors do not propagate into later predictions. A cluster of seven errors placed inside one window, followed by a continuously inverted stream starting on a window boundary, separates the drop threshold from off-by-one thresholds. Finally, a further inverted stretch and a clean restart show that the counters freeze while hunting and that relock happens within the bound.

// File: rtl/prbs_chk_pkg.sv
package prbs_chk_pkg;

    typedef enum logic {
        PH_HUNT  = 1'b0,
        PH_TRACK = 1'b1
    } phase_t;

    // Second feedback tap (1-based) of the polynomial for each order.
    function automatic int tap_for(input int order);
        case (order)
            7:       return 6;
            9:       return 5;
            11:      return 9;
            15:      return 14;
            23:      return 18;
            31:      return 28;
            default: return 1;
        endcase
    endfunction

endpackage

// File: rtl/prbs_chk_step.sv
module prbs_chk_step #(
    parameter int ORDER = 7,
    parameter int W     = 1
) (
    input  logic [ORDER-1:0]               st_i,
    input  logic [W-1:0]                   rx_i,
    input  logic                           hunt_i,
    input  logic [$clog2(ORDER+1)-1:0]     fill_i,
    input  logic [$clog2(ORDER+1)-1:0]     run_i,
    output logic [ORDER-1:0]               st_o,
    output logic [W-1:0]                   miss_o,
    output logic [$clog2(ORDER+1)-1:0]     fill_o,
    output logic [$clog2(ORDER+1)-1:0]     run_o,
    output logic                           hit_o
);
    localparam int TAP = prbs_chk_pkg::tap_for(ORDER);
    localparam int CW  = $clog2(ORDER+1);

    logic [ORDER-1:0] s;
    logic [CW-1:0]    f;
    logic [CW-1:0]    r;
    logic             p;

    // Unrolled W-bit step: bit 0 is handled first.
    always_comb begin
        s      = st_i;
        f      = fill_i;
        r      = run_i;
        p      = 1'b0;
        hit_o  = 1'b0;
        miss_o = '0;
        for (int i = 0; i < W; i++) begin
            p         = s[ORDER-1] ^ s[TAP-1];
            miss_o[i] = p ^ rx_i[i];
            if (hunt_i) begin
                if (f != CW'(ORDER)) begin
                    f = f + CW'(1);
                end else if (!miss_o[i]) begin
                    if (r != CW'(ORDER)) r = r + CW'(1);
                end else begin
                    r = '0;
                end
                if (r == CW'(ORDER)) hit_o = 1'b1;
                s = {s[ORDER-2:0], rx_i[i]};
            end else begin
                s = {s[ORDER-2:0], p};
            end
        end
        st_o   = s;
        fill_o = f;
        run_o  = r;
    end
endmodule

// File: rtl/prbs_chk_window.sv
module prbs_chk_window #(
    parameter int W         = 1,
    parameter int WIN_BITS  = 64,
    parameter int ERR_LIMIT = 8
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     track_i,
    input  logic [$clog2(W+1)-1:0]   miss_n_i,
    output logic                     drop_o
);
    localparam int WIN_WORDS = WIN_BITS / W;
    localparam int IW        = (WIN_WORDS > 2) ? $clog2(WIN_WORDS) : 1;
    localparam int SW        = $clog2(ERR_LIMIT + W + 1);

    logic [IW-1:0] idx_q;
    logic [SW-1:0] acc_q;
    logic [SW-1:0] sum;

    always_comb begin
        sum    = acc_q + SW'(miss_n_i);
        drop_o = track_i && (sum >= SW'(ERR_LIMIT));
    end

    // Tumbling window counted in words, restarted whenever lock is absent.
    always_ff @(posedge clk) begin
        if (rst || !track_i || drop_o) begin
            idx_q <= '0;
            acc_q <= '0;
        end else if (idx_q == IW'(WIN_WORDS-1)) begin
            idx_q <= '0;
            acc_q <= '0;
        end else begin
            idx_q <= idx_q + IW'(1);
            acc_q <= sum;
        end
    end
endmodule

// File: rtl/prbs_chk_tally.sv
module prbs_chk_tally #(
    parameter int W     = 1,
    parameter int CNT_W = 64
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     track_i,
    input  logic [$clog2(W+1)-1:0]   miss_n_i,
    output logic [CNT_W-1:0]         word_cnt_o,
    output logic [CNT_W-1:0]         err_cnt_o
);
    always_ff @(posedge clk) begin
        if (rst) begin
            word_cnt_o <= '0;
            err_cnt_o  <= '0;
        end else if (track_i) begin
            word_cnt_o <= word_cnt_o + CNT_W'(1);
            err_cnt_o  <= err_cnt_o + CNT_W'(miss_n_i);
        end
    end
endmodule

// File: rtl/prbs_lock_checker.sv
module prbs_lock_checker #(
    parameter int ORDER     = 7,
    parameter int W         = 1,
    parameter int CNT_W     = 64,
    parameter int WIN_BITS  = 64,
    parameter int ERR_LIMIT = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [W-1:0]      rx_word,
    output logic              locked,
    output logic [CNT_W-1:0]  word_count,
    output logic [CNT_W-1:0]  error_count
);
    import prbs_chk_pkg::*;

    localparam int CW = $clog2(ORDER+1);
    localparam int NW = $clog2(W+1);

    phase_t           phase_q;
    logic [ORDER-1:0] st_q, st_nx;
    logic [CW-1:0]    fill_q, fill_nx;
    logic [CW-1:0]    run_q, run_nx;
    logic [W-1:0]     miss;
    logic             hit;
    logic             drop;
    logic             track;
    logic [NW-1:0]    err_num;

    assign track  = (phase_q == PH_TRACK);
    assign locked = track;

    prbs_chk_step #(.ORDER(ORDER), .W(W)) step_i (
        .st_i   (st_q),
        .rx_i   (rx_word),
        .hunt_i (!track),
        .fill_i (fill_q),
        .run_i  (run_q),
        .st_o   (st_nx),
        .miss_o (miss),
        .fill_o (fill_nx),
        .run_o  (run_nx),
        .hit_o  (hit)
    );

    always_comb begin
        err_num = '0;
        for (int i = 0; i < W; i++) begin
            err_num = err_num + NW'(miss[i] & track);
        end
    end

    prbs_chk_window #(.W(W), .WIN_BITS(WIN_BITS), .ERR_LIMIT(ERR_LIMIT)) win_i (
        .clk      (clk),
        .rst      (rst),
        .track_i  (track),
        .miss_n_i (err_num),
        .drop_o   (drop)
    );

    prbs_chk_tally #(.W(W), .CNT_W(CNT_W)) tally_i (
        .clk        (clk),
        .rst        (rst),
        .track_i    (track),
        .miss_n_i   (err_num),
        .word_cnt_o (word_count),
        .err_cnt_o  (error_count)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q <= PH_HUNT;
            st_q    <= '0;
            fill_q  <= '0;
            run_q   <= '0;
        end else begin
            st_q <= st_nx;
            if (!track) begin
                fill_q <= fill_nx;
                run_q  <= run_nx;
                if (hit) phase_q <= PH_TRACK;
            end else if (drop) begin
                phase_q <= PH_HUNT;
                fill_q  <= '0;
                run_q   <= '0;
            end
        end
    end
endmodule

// File: rtl/prbs_lock_checker_sva.sv
module prbs_lock_checker_sva #(
    parameter int ORDER = 7,
    parameter int W     = 1,
    parameter int CNT_W = 64
) (
    input logic                       clk,
    input logic                       rst,
    input logic                       locked,
    input logic [CNT_W-1:0]           word_cnt,
    input logic [CNT_W-1:0]           err_cnt,
    input logic [$clog2(W+1)-1:0]     err_num,
    input logic [$clog2(ORDER+1)-1:0] fill
);
    p_reset_clear_r1: assert property (@(posedge clk)
        rst |=> (!locked && word_cnt == '0 && err_cnt == '0));

    p_lock_after_fill_r2: assert property (@(posedge clk) disable iff (rst)
        $rose(locked) |-> (fill == ($clog2(ORDER+1))'(ORDER)));

    p_word_step_r4: assert property (@(posedge clk) disable iff (rst)
        locked |=> (word_cnt == $past(word_cnt) + CNT_W'(1)));

    p_word_hold_r4: assert property (@(posedge clk) disable iff (rst)
        !locked |=> $stable(word_cnt));

    p_err_step_r5: assert property (@(posedge clk) disable iff (rst)
        locked |=> (err_cnt == $past(err_cnt) + CNT_W'($past(err_num))));

    p_drop_on_error_r7: assert property (@(posedge clk) disable iff (rst)
        $fell(locked) |-> ($past(err_num) != '0));

    p_err_hold_r9: assert property (@(posedge clk) disable iff (rst)
        !locked |=> $stable(err_cnt));
endmodule

bind prbs_lock_checker prbs_lock_checker_sva #(
    .ORDER(ORDER), .W(W), .CNT_W(CNT_W)
) sva_i (
    .clk      (clk),
    .rst      (rst),
    .locked   (locked),
    .word_cnt (word_count),
    .err_cnt  (error_count),
    .err_num  (err_num),
    .fill     (fill_q)
);

// File: tb/prbs_lock_checker_tb_top.sv
module prbs_lock_checker_tb_top;
    localparam int CLK_PERIOD = 10;

    logic clk = 1'b0;
    always #(CLK_PERIOD/2) clk = ~clk;

    logic        rst_a = 1'b1;
    logic        rst_b = 1'b1;
    logic [0:0]  rx_a  = '0;
    logic [3:0]  rx_b  = '0;
    logic        lk_a, lk_b;
    logic [63:0] wc_a, ec_a, wc_b, ec_b;

    int checks = 0;
    int errors = 0;

    logic [6:0] ga = 7'h7F;   // x^7 + x^6 + 1 model
    logic [8:0] gb = 9'h1FF;  // x^9 + x^5 + 1 model

    prbs_lock_checker #(.ORDER(7), .W(1)) dut_i (
        .clk(clk), .rst(rst_a), .rx_word(rx_a),
        .locked(lk_a), .word_count(wc_a), .error_count(ec_a)
    );

    prbs_lock_checker #(.ORDER(9), .W(4)) dut_b_i (
        .clk(clk), .rst(rst_b), .rx_word(rx_b),
        .locked(lk_b), .word_count(wc_b), .error_count(ec_b)
    );

    task automatic chk(input string req, input longint unsigned act, input longint unsigned exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic step_a(input logic flip);
        logic b;
        @(negedge clk);
        b  = ga[6] ^ ga[5];
        ga = {ga[5:0], b};
        rx_a[0] = b ^ flip;
        @(posedge clk);
        #1;
    endtask

    task automatic step_b(input logic [3:0] flips);
        logic b;
        logic [3:0] w;
        @(negedge clk);
        for (int i = 0; i < 4; i++) begin
            b    = gb[8] ^ gb[4];
            gb   = {gb[7:0], b};
            w[i] = b;
        end
        rx_b = w ^ flips;
        @(posedge clk);
        #1;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL R2 watchdog actual timeout expected completion");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        int n;
        repeat (3) @(posedge clk);
        #1;
        // R1 reset state
        chk("R1 locked in reset", lk_a, 0);
        chk("R1 words in reset", wc_a, 0);
        chk("R1 errors in reset", ec_a, 0);

        // Serial order 7: lock timing
        rst_a = 1'b0;
        for (int k = 0; k < 13; k++) step_a(1'b0);
        chk("R2 not locked before word 14", lk_a, 0);
        step_a(1'b0);
        chk("R2 locked at word 14", lk_a, 1);
        chk("R4 no words counted at lock", wc_a, 0);

        for (int k = 0; k < 10; k++) step_a(1'b0);
        chk("R4 word count", wc_a, 10);
        step_a(1'b1);                       // word 10 corrupted
        chk("R5 single error count", ec_a, 1);
        chk("R5 stays locked", lk_a, 1);
        for (int k = 11; k < 64; k++) step_a(1'b0);
        chk("R6 no propagated errors", ec_a, 1);
        chk("R4 word count 64", wc_a, 64);

        for (int k = 64; k < 71; k++) step_a(1'b1);   // seven in window 1
        chk("R7 seven errors keep lock", lk_a, 1);
        chk("R7 error count", ec_a, 8);
        for (int k = 71; k < 128; k++) step_a(1'b0);

        for (int j = 0; j < 8; j++) begin             // window 2, all wrong
            step_a(1'b1);
            chk("R8 error count rises each word", ec_a, 9 + j);
            if (j == 6) chk("R7 locked at seventh error", lk_a, 1);
        end
        chk("R7 drop at eighth error", lk_a, 0);
        chk("R4 word count at drop", wc_a, 136);

        for (int k = 0; k < 40; k++) step_a(1'b1);
        chk("R9 errors frozen while hunting", ec_a, 16);
        chk("R4 words frozen while hunting", wc_a, 136);
        chk("R9 inverted data never relocks", lk_a, 0);

        n = 0;
        while (!lk_a && n < 300) begin
            step_a(1'b0);
            n++;
        end
        chk("R9 relock within 2*ORDER", (n <= 14) ? 1 : 0, 1);
        chk("R2 relock within sequence bound", (n <= 254) ? 1 : 0, 1);
        for (int k = 0; k < 100; k++) step_a(1'b0);
        chk("R6 clean after relock", ec_a, 16);
        chk("R4 word count after relock", wc_a, 236);

        rst_a = 1'b1;
        @(posedge clk);
        #1;
        chk("R1 reset clears errors", ec_a, 0);
        chk("R1 reset clears words", wc_a, 0);
        chk("R1 reset clears lock", lk_a, 0);

        // Word mode, order 9, four bits per word
        rst_b = 1'b0;
        for (int k = 0; k < 4; k++) step_b(4'b0000);
        chk("R3 not locked after four words", lk_b, 0);
        step_b(4'b0000);
        chk("R3 locked on fifth word", lk_b, 1);
        for (int k = 0; k < 3; k++) step_b(4'b0000);
        chk("R3 clean word stream", ec_b, 0);
        step_b(4'b0100);
        chk("R5 one bit in word", ec_b, 1);
        for (int k = 0; k < 3; k++) step_b(4'b0000);
        chk("R6 word mode no propagation", ec_b, 1);
        chk("R4 word mode count", wc_b, 7);
        step_b(4'b1001);
        chk("R5 two bits in word", ec_b, 3);
        chk("R5 word mode stays locked", lk_b, 1);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule